// File: doc/BRIEF.md
# Sprocket-Timed Tape Character Capture

This block takes the seven data levels of a tape head, read in parallel, and turns each character into a timed write into a 120-location character store. A data level that pulses high marks its bit in a first-stage latch. Each sprocket pulse moves the first-stage contents into a second-stage register and empties the first stage. A fixed number of clock cycles later, a write window opens for a fixed length. During the window the block drives one write gate per level. A gate is active only for a level that read zero, so the gates carry the complement of the character. A second, later strobe marks a point inside the window. When the window closes, the second stage is emptied and the write address moves forward by one.

The block also counts the stored characters. Once the store is full, the next sprocket yields an end-of-read pulse instead of a write. When the read cycle ends, a flag is raised if the count is anything other than exactly 120. A sprocket that arrives while a capture is still running is treated as an overrun. While the inhibit input is high, the first stage is held empty and sprockets are ignored. A read-start pulse clears the address, the flags and both capture stages. Delays are in clock cycles. The defaults suit a 1 MHz reference: a 5-cycle delay to the window, a 30-cycle window, a second strobe after 8 cycles, and a shortest sprocket spacing of 40 cycles.

Top module: `tape_char_capture`

## Requirements
- R1: Every data level that is high in any cycle between two accepted sprockets becomes a one in the captured character. Levels are sampled on each clock edge. Level bit i maps to write gate bit i.
- R2: While `wr_window` is high, `wr_gate` equals the bitwise complement of the captured character. Outside the window, `wr_gate` is all zeros.
- R3: Call E0 the clock edge that samples an accepted sprocket. `wr_window` is then high in the cycles after edges E5 through E34 (window edges SP1_DLY to SP1_DLY+WIN_LEN-1), which is 30 cycles. `sp1_strobe` is high for one cycle, the first window cycle. `sp2_strobe` is high for one cycle, the cycle after edge E8 (SP2_DLY).
- R4: `wr_addr` keeps its value through the last window cycle. It increases by one in the cycle that follows.
- R5: While `inhibit` is high, the first stage is held empty and a sprocket is ignored. An ignored sprocket opens no window, leaves the address unchanged and sets no overrun flag.
- R6: A sprocket sampled while a capture is in progress (delay or window) sets the sticky `overrun_err`. It leaves the running window, the address and the first stage untouched.
- R7: When `wr_addr` equals 120, an accepted sprocket produces a one-cycle `end_read` pulse in the cycle after its edge. It opens no window and leaves the address at 120.
- R8: A `read_end` pulse sets the sticky `count_err` when `wr_addr` is not 120. It leaves `count_err` clear when `wr_addr` is exactly 120.
- R9: Reset and `read_start` clear `wr_addr`, `overrun_err`, `count_err`, the window and both capture stages.
- R10: Sprockets spaced 40 cycles apart are all captured, with no overrun. After 120 of them, `wr_addr` reads 120.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| read_start | input | 1 | Start of a read cycle; clears address, flags and stages |
| read_end | input | 1 | End of a read cycle; triggers the exact-count check |
| inhibit | input | 1 | Combined inhibit condition; holds stage one empty and blocks sprockets |
| level_in | input | 7 | Data level pulses from the head amplifiers |
| sprocket | input | 1 | Sprocket pulse, one cycle per character |
| wr_gate | output | 7 | Per-level write gates, active for levels that read zero |
| wr_window | output | 1 | Write window |
| sp1_strobe | output | 1 | Strobe at window opening |
| sp2_strobe | output | 1 | Later strobe inside the window |
| wr_addr | output | 7 | Write address and character count, 0 to 120 |
| end_read | output | 1 | One-cycle pulse when a sprocket arrives with the store full |
| overrun_err | output | 1 | Sticky: sprocket during a running capture |
| count_err | output | 1 | Sticky: read ended with a count other than 120 |

## Verification
The hardest state to reach is the full store. The end-of-read pulse and the exact-count check only mean something after 120 windows have run to completion. The stimulus therefore drives 120 sprockets at the shortest allowed spacing of 40 cycles, and checks that no overrun appears along the way. It then sends one more sprocket and the end-of-read request. The overrun case uses the same timing arithmetic: a second sprocket is placed in a known cycle inside the open window, and the bench then checks that the window length and the address step are unchanged.

// File: rtl/tc_pkg.sv
package tc_pkg;

    parameter int TC_CHAR_W    = 7;
    parameter int TC_LOCATIONS = 120;
    parameter int TC_SP1_DLY   = 5;
    parameter int TC_SP2_DLY   = 8;
    parameter int TC_WIN_LEN   = 30;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DELAY  = 2'd1,
        PH_WINDOW = 2'd2
    } tc_phase_e;

    typedef struct packed {
        logic overrun;
        logic count_bad;
    } tc_flags_t;

    function automatic int f_count_w(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tc_strobe_timer.sv
module tc_strobe_timer
    import tc_pkg::*;
#(
    parameter int SP1_DLY = TC_SP1_DLY,
    parameter int SP2_DLY = TC_SP2_DLY,
    parameter int WIN_LEN = TC_WIN_LEN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      abort,
    input  logic      go,
    output logic      busy,
    output logic      win,
    output logic      sp1,
    output logic      sp2,
    output logic      close,
    output tc_phase_e phase
);
    localparam int LAST = SP1_DLY + WIN_LEN;
    localparam int CW   = f_count_w(LAST);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            if (go) cnt <= CW'(1);
        end else if (cnt == CW'(LAST)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        busy  = (cnt != '0);
        win   = (cnt > CW'(SP1_DLY));
        sp1   = (cnt == CW'(SP1_DLY + 1));
        sp2   = (cnt == CW'(SP2_DLY + 1));
        close = (cnt == CW'(LAST));
        if (!busy)    phase = PH_IDLE;
        else if (win) phase = PH_WINDOW;
        else          phase = PH_DELAY;
    end

    p_open_after_delay_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(win) |-> ($past(cnt) == CW'(SP1_DLY)));
    p_sp2_inside_r3: assert property (@(posedge clk) disable iff (rst)
        sp2 |-> (phase == PH_WINDOW));

endmodule

// File: rtl/tc_level_latch.sv
module tc_level_latch
    import tc_pkg::*;
#(
    parameter int CHAR_W = TC_CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              hold_clr,
    input  logic [CHAR_W-1:0] levels,
    input  logic              jam,
    input  logic              load,
    input  logic              drop,
    output logic [CHAR_W-1:0] stage2
);
    logic [CHAR_W-1:0] stage1;

    genvar g;
    generate
        for (g = 0; g < CHAR_W; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst || clr || hold_clr || jam) stage1[g] <= 1'b0;
                else if (levels[g])                stage1[g] <= 1'b1;
            end
            always_ff @(posedge clk) begin
                if (rst || clr || drop) stage2[g] <= 1'b0;
                else if (load)          stage2[g] <= stage1[g];
            end
        end
    endgenerate

    p_inhibit_empty_r5: assert property (@(posedge clk) disable iff (rst)
        hold_clr |=> (stage1 == '0));

endmodule

// File: rtl/tc_char_counter.sv
module tc_char_counter
    import tc_pkg::*;
#(
    parameter int LOCATIONS = TC_LOCATIONS,
    parameter int AW        = f_count_w(LOCATIONS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          advance,
    input  logic          spr_ok,
    input  logic          spr_busy,
    input  logic          read_end,
    output logic [AW-1:0] addr,
    output logic          full,
    output logic          end_read,
    output tc_flags_t     flags
);
    assign full = (addr == AW'(LOCATIONS));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            addr     <= '0;
            end_read <= 1'b0;
            flags    <= '0;
        end else begin
            if (advance && !full) addr <= addr + 1'b1;
            end_read <= spr_ok && full;
            if (spr_busy) flags.overrun <= 1'b1;
            if (read_end && !full) flags.count_bad <= 1'b1;
        end
    end

    p_addr_limit_r7: assert property (@(posedge clk) disable iff (rst)
        addr <= AW'(LOCATIONS));
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (advance && !full && !clr) |=> (addr == $past(addr) + 1'b1));
    p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flags.overrun && !clr) |=> flags.overrun);

endmodule

// File: rtl/tape_char_capture.sv
module tape_char_capture
    import tc_pkg::*;
#(
    parameter int CHAR_W    = TC_CHAR_W,
    parameter int LOCATIONS = TC_LOCATIONS,
    parameter int SP1_DLY   = TC_SP1_DLY,
    parameter int SP2_DLY   = TC_SP2_DLY,
    parameter int WIN_LEN   = TC_WIN_LEN,
    parameter int AW        = f_count_w(LOCATIONS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              read_start,
    input  logic              read_end,
    input  logic              inhibit,
    input  logic [CHAR_W-1:0] level_in,
    input  logic              sprocket,
    output logic [CHAR_W-1:0] wr_gate,
    output logic              wr_window,
    output logic              sp1_strobe,
    output logic              sp2_strobe,
    output logic [AW-1:0]     wr_addr,
    output logic              end_read,
    output logic              overrun_err,
    output logic              count_err
);
    logic              busy, close, full, accepted, go;
    logic [CHAR_W-1:0] stage2;
    tc_phase_e         phase;
    tc_flags_t         flags;

    assign accepted = sprocket && !inhibit && !busy;
    assign go       = accepted && !full;

    tc_strobe_timer #(.SP1_DLY(SP1_DLY), .SP2_DLY(SP2_DLY), .WIN_LEN(WIN_LEN)) u_timer (
        .clk(clk), .rst(rst), .abort(read_start), .go(go),
        .busy(busy), .win(wr_window), .sp1(sp1_strobe), .sp2(sp2_strobe),
        .close(close), .phase(phase)
    );

    tc_level_latch #(.CHAR_W(CHAR_W)) u_latch (
        .clk(clk), .rst(rst), .clr(read_start), .hold_clr(inhibit),
        .levels(level_in), .jam(accepted), .load(go), .drop(close),
        .stage2(stage2)
    );

    tc_char_counter #(.LOCATIONS(LOCATIONS), .AW(AW)) u_count (
        .clk(clk), .rst(rst), .clr(read_start), .advance(close),
        .spr_ok(accepted), .spr_busy(sprocket && !inhibit && busy),
        .read_end(read_end), .addr(wr_addr), .full(full),
        .end_read(end_read), .flags(flags)
    );

    assign wr_gate     = wr_window ? ~stage2 : '0;
    assign overrun_err = flags.overrun;
    assign count_err   = flags.count_bad;

    p_end_no_window_r7: assert property (@(posedge clk) disable iff (rst)
        end_read |-> (phase == PH_IDLE));
    p_clear_start_r9: assert property (@(posedge clk) disable iff (rst)
        read_start |=> (wr_addr == '0 && !overrun_err && !count_err && !wr_window));

endmodule

// File: tb/sim_tape_char_capture.sv
module sim_tape_char_capture;
    logic       clk = 1'b0;
    logic       rst, read_start, read_end, inhibit, sprocket;
    logic [6:0] level_in, wr_gate, wr_addr;
    logic       wr_window, sp1_strobe, sp2_strobe, end_read, overrun_err, count_err;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    tape_char_capture u0 (
        .clk(clk), .rst(rst), .read_start(read_start), .read_end(read_end),
        .inhibit(inhibit), .level_in(level_in), .sprocket(sprocket),
        .wr_gate(wr_gate), .wr_window(wr_window), .sp1_strobe(sp1_strobe),
        .sp2_strobe(sp2_strobe), .wr_addr(wr_addr), .end_read(end_read),
        .overrun_err(overrun_err), .count_err(count_err)
    );

    // {levels pulsed, second level pulse}
    localparam logic [13:0] VEC [8] = '{
        {7'h00, 7'h00}, {7'h7F, 7'h00}, {7'h01, 7'h40}, {7'h2A, 7'h00},
        {7'h55, 7'h2A}, {7'h10, 7'h10}, {7'h03, 7'h0C}, {7'h00, 7'h7F}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // sprocket at negedge 0; observe negedges 1..39
    task automatic capture(input logic [6:0] a, input logic [6:0] b,
                           output int first, output int len, output int sp1at,
                           output int sp2at, output logic [6:0] gmid,
                           output logic [6:0] ad35, output logic [6:0] ad36);
        @(negedge clk); level_in = a;
        @(negedge clk); level_in = b;
        @(negedge clk); level_in = '0; sprocket = 1'b1;
        first = -1; len = 0; sp1at = -1; sp2at = -1; gmid = '0; ad35 = '0; ad36 = '0;
        for (int i = 1; i < 40; i++) begin
            @(negedge clk); sprocket = 1'b0;
            if (wr_window) begin
                if (first < 0) first = i;
                len++;
            end
            if (sp1_strobe) sp1at = i;
            if (sp2_strobe) sp2at = i;
            if (i == 20) gmid = wr_gate;
            if (i == 35) ad35 = wr_addr;
            if (i == 36) ad36 = wr_addr;
        end
    endtask

    task automatic fast_run(input int n, output int miss);
        miss = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk); sprocket = 1'b1;
            @(negedge clk); sprocket = 1'b0;
            for (int i = 2; i < 40; i++) begin
                @(negedge clk);
                if (i == 20 && wr_gate != 7'h7F) miss++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int f, l, s1, s2, miss;
        logic [6:0] gm, a35, a36;
        rst = 1'b1; read_start = 0; read_end = 0; inhibit = 0; sprocket = 0; level_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_addr == 0 && !overrun_err && !count_err && !wr_window && wr_gate == 0,
            "R9 reset state", int'(wr_addr), 0);

        // vector walk: R1 R2 R3 R4
        for (int v = 0; v < 8; v++) begin
            logic [6:0] a_lv, b_lv;
            logic [6:0] prev;
            a_lv = VEC[v][13:7]; b_lv = VEC[v][6:0]; prev = wr_addr;
            capture(a_lv, b_lv, f, l, s1, s2, gm, a35, a36);
            chk(gm == ~(a_lv | b_lv), "R1 R2 gate is complement of OR of levels", int'(gm), int'(~(a_lv | b_lv)));
            chk(f == 6 && l == 30, "R3 window start/length", f * 100 + l, 630);
            chk(s1 == 6 && s2 == 9, "R3 strobe cycles", s1 * 100 + s2, 609);
            chk(a35 == prev && a36 == prev + 7'd1, "R4 address step after window",
                int'(a36), int'(prev) + 1);
        end
        @(negedge clk);
        chk(wr_gate == 0, "R2 gates idle outside window", int'(wr_gate), 0);

        // R5 inhibit
        inhibit = 1'b1;
        capture(7'h7F, 7'h00, f, l, s1, s2, gm, a35, a36);
        chk(f == -1 && wr_addr == 8 && !overrun_err, "R5 inhibited sprocket ignored", f, -1);
        inhibit = 1'b0;
        capture(7'h00, 7'h00, f, l, s1, s2, gm, a35, a36);
        chk(gm == 7'h7F, "R5 stage one held empty under inhibit", int'(gm), 127);

        // R6 overrun
        @(negedge clk); level_in = 7'h05;
        @(negedge clk); level_in = '0; sprocket = 1'b1;
        f = -1; l = 0;
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            sprocket = (i == 10);
            if (wr_window) begin if (f < 0) f = i; l++; end
            if (i == 11) chk(overrun_err, "R6 overrun flag set", int'(overrun_err), 1);
            if (i == 20) chk(wr_gate == 7'h7A, "R6 window data untouched", int'(wr_gate), 122);
        end
        chk(f == 6 && l == 30 && wr_addr == 10, "R6 window and address unchanged", int'(wr_addr), 10);

        // R9 read_start clear, then R10 full run
        @(negedge clk); read_start = 1'b1;
        @(negedge clk); read_start = 1'b0;
        chk(wr_addr == 0 && !overrun_err && !count_err, "R9 read_start clears", int'(wr_addr), 0);
        fast_run(120, miss);
        @(negedge clk);
        chk(miss == 0 && !overrun_err, "R10 40-cycle spacing captured", miss, 0);
        chk(wr_addr == 120, "R10 count reaches 120", int'(wr_addr), 120);

        // R7 end_read
        sprocket = 1'b1;
        @(negedge clk); sprocket = 1'b0;
        chk(end_read, "R7 end_read pulse", int'(end_read), 1);
        @(negedge clk);
        chk(!end_read, "R7 end_read one cycle", int'(end_read), 0);
        f = 0;
        for (int i = 0; i < 38; i++) begin @(negedge clk); if (wr_window) f++; end
        chk(f == 0 && wr_addr == 120, "R7 no window when full", f, 0);

        // R8 exact count
        read_end = 1'b1; @(negedge clk); read_end = 1'b0; @(negedge clk);
        chk(!count_err, "R8 count of 120 accepted", int'(count_err), 0);
        read_start = 1'b1; @(negedge clk); read_start = 1'b0;
        fast_run(1, miss);
        read_end = 1'b1; @(negedge clk); read_end = 1'b0; @(negedge clk);
        chk(count_err, "R8 short count flagged", int'(count_err), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule